// File: doc/BRIEF.md
# Strap Capture and Frequency Code Selector

This block sits beside the clock outputs that share their pads with configuration straps. It samples the straps while power-on reset is held, keeps those levels for the rest of operation, and enables the pad drivers once reset has ended. From then on the pads carry clocks.

It presents one registered 5-bit frequency code to the synthesizer. A software-select bit chooses where the code comes from: the latched straps or a code supplied by the register file. The register file also gets the latched strap levels back, inverted, for readback.

A third part gates a secondary clock enable from a PCI-rate tick stream. Depending on a rate-select bit, it passes every tick or every other tick.

Top module: `strap_freq_select`

## Requirements
- R1: While `por_n` is low, the strap latch loads the level on `strap_pad_i` at every rising clock edge. Once `por_n` is high, the latch holds its value, and later changes on `strap_pad_i` have no effect on `freq_code_o` or `strap_rb_n_o`.
- R2: Every bit of `pad_oe_o` is 0 whenever `por_n` is low, with an asynchronous clear. All bits become 1 at the first rising edge at which `por_n` is sampled high, and they stay 1 until the next reset.
- R3: `freq_code_o` is 0 during reset. At each rising edge with `por_n` high, it loads `sw_code_i` when `sw_sel_i` is 1, or the latched strap code when `sw_sel_i` is 0. It therefore follows its source one edge later. Bit i of the code is strap pad i.
- R4: `strap_rb_n_o` is the bitwise inverse of the latched strap code, with bit i taken from pad i.
- R5: With `apic_half_i` = 0, `apic_tick_o` equals `pci_tick_i` delayed by one edge. With `apic_half_i` = 1, it passes the 1st, 3rd, 5th and so on PCI tick counted from reset release or from entry into half mode, and drops the others. It is 0 during reset.
- R6: A second assertion of `por_n` samples the pads again, and the new strap code takes over after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, running during reset |
| por_n | input | 1 | Power-on reset, active low |
| strap_pad_i | input | 5 | Pad levels seen while the pads are inputs |
| sw_sel_i | input | 1 | 1 selects the software code, 0 selects the straps |
| sw_code_i | input | 5 | Frequency code from the register file |
| apic_half_i | input | 1 | 1 selects half the PCI rate, 0 selects the full rate |
| pci_tick_i | input | 1 | One-cycle pulse per PCI clock period |
| pad_oe_o | output | 5 | Per-pad output-driver enable |
| freq_code_o | output | 5 | Registered frequency code |
| strap_rb_n_o | output | 5 | Inverted latched straps for readback |
| apic_tick_o | output | 1 | Secondary clock enable |

## Verification
Each output has its own latency:
- `freq_code_o` and `apic_tick_o` reflect their inputs one rising edge later.
- `pad_oe_o` rises at the first edge after release.
- `strap_rb_n_o` changes in the same cycle as the latch that drives it.

The bench updates its reference model at each rising edge from the inputs held at that edge. It compares all outputs at the following falling edge, before new stimulus is driven, so every result is checked exactly one edge after its cause.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t pick_code(input logic use_sw, input code_t sw, input code_t hw);
    return use_sw ? sw : hw;
  endfunction

  function automatic logic half_pass(input logic tick, input logic odd_phase);
    return tick & ~odd_phase;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] strap_o,
  output logic [W-1:0] oe_o
);
  logic capture_en;
  assign capture_en = ~por_n;

  always_ff @(posedge clk) begin
    if (capture_en) strap_o <= pad_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_oe
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) oe_o[g] <= 1'b0;
      else        oe_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/code_select.sv
module code_select
  import strap_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  sel_i,
  input  code_t sw_i,
  input  code_t hw_i,
  output code_t code_o
);
  code_t next_code;
  assign next_code = pick_code(sel_i, sw_i, hw_i);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) code_o <= '0;
    else        code_o <= next_code;
  end
endmodule

// File: rtl/apic_rate.sv
module apic_rate
  import strap_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic half_i,
  input  logic tick_i,
  output logic tick_o
);
  logic odd_q;
  logic pass;

  assign pass = half_i ? half_pass(tick_i, odd_q) : tick_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      odd_q  <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= pass;
      if (!half_i)     odd_q <= 1'b0;
      else if (tick_i) odd_q <= ~odd_q;
    end
  end
endmodule

// File: rtl/strap_freq_select.sv
module strap_freq_select
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic [CODE_W-1:0] strap_pad_i,
  input  logic              sw_sel_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic              apic_half_i,
  input  logic              pci_tick_i,
  output logic [CODE_W-1:0] pad_oe_o,
  output logic [CODE_W-1:0] freq_code_o,
  output logic [CODE_W-1:0] strap_rb_n_o,
  output logic              apic_tick_o
);
  code_t strap_q;

  strap_latch #(.W(CODE_W)) u_latch (
    .clk(clk), .por_n(por_n), .pad_i(strap_pad_i), .strap_o(strap_q), .oe_o(pad_oe_o)
  );

  code_select u_sel (
    .clk(clk), .por_n(por_n), .sel_i(sw_sel_i), .sw_i(sw_code_i),
    .hw_i(strap_q), .code_o(freq_code_o)
  );

  apic_rate u_apic (
    .clk(clk), .por_n(por_n), .half_i(apic_half_i), .tick_i(pci_tick_i), .tick_o(apic_tick_o)
  );

  assign strap_rb_n_o = ~strap_q;
endmodule

// File: rtl/strap_freq_select_chk.sv
module strap_freq_select_chk
  import strap_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic [CODE_W-1:0] strap_pad_i,
  input logic              sw_sel_i,
  input logic [CODE_W-1:0] sw_code_i,
  input logic              apic_half_i,
  input logic              pci_tick_i,
  input logic [CODE_W-1:0] pad_oe_o,
  input logic [CODE_W-1:0] freq_code_o,
  input logic [CODE_W-1:0] strap_rb_n_o,
  input logic              apic_tick_o
);
  // R1: once drivers are on, the latched straps never move
  a_r1_hold: assert property (@(posedge clk) disable iff (!por_n)
    (&pad_oe_o) |=> $stable(strap_rb_n_o));
  // R2: drivers stay enabled after release
  a_r2_oe_stay: assert property (@(posedge clk) disable iff (!por_n)
    (&pad_oe_o) |=> (&pad_oe_o));
  // R2: all enables move together
  a_r2_oe_uniform: assert property (@(posedge clk) disable iff (!por_n)
    (pad_oe_o == '0) || (&pad_oe_o));
  // R3: software source
  a_r3_sw: assert property (@(posedge clk) disable iff (!por_n)
    sw_sel_i |=> freq_code_o == $past(sw_code_i));
  // R3 R4: strap source, seen through the inverted readback
  a_r3_hw: assert property (@(posedge clk) disable iff (!por_n)
    !sw_sel_i |=> freq_code_o == ~$past(strap_rb_n_o));
  // R5: full rate follows the tick
  a_r5_full: assert property (@(posedge clk) disable iff (!por_n)
    !apic_half_i |=> apic_tick_o == $past(pci_tick_i));
  // R5: half rate never emits twice in a row
  a_r5_half: assert property (@(posedge clk) disable iff (!por_n)
    ($past(apic_half_i) && apic_half_i && apic_tick_o) |=> !apic_tick_o);
endmodule

bind strap_freq_select strap_freq_select_chk u_chk (.*);

// File: tb/strap_freq_select_bench.sv
module strap_freq_select_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [4:0] strap_pad_i = '0;
  logic       sw_sel_i = 1'b0;
  logic [4:0] sw_code_i = '0;
  logic       apic_half_i = 1'b1;
  logic       pci_tick_i = 1'b0;
  logic [4:0] pad_oe_o, freq_code_o, strap_rb_n_o;
  logic       apic_tick_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // behavioural reference state
  int m_strap = 0, m_code = 0, m_oe = 0, m_tick = 0, m_odd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_freq_select u_strap_freq_select (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cycles++;
    if (!por_n) begin
      m_strap = strap_pad_i;
      m_oe = 0; m_code = 0; m_tick = 0; m_odd = 0;
    end else begin
      m_oe = 1;
      m_code = sw_sel_i ? sw_code_i : m_strap;
      if (!apic_half_i) begin
        m_tick = pci_tick_i; m_odd = 0;
      end else begin
        m_tick = (pci_tick_i && m_odd == 0) ? 1 : 0;
        if (pci_tick_i) m_odd = 1 - m_odd;
      end
    end
    @(negedge clk);
    chk("R1 R4 readback", strap_rb_n_o, (~m_strap) & 5'h1f);
    chk("R2 pad enable", pad_oe_o, m_oe ? 5'h1f : 5'h00);
    chk("R3 freq code", freq_code_o, m_code);
    chk("R5 apic tick", apic_tick_o, m_tick);
  endtask

  task automatic run(input int n, input bit toggle_tick);
    for (int i = 0; i < n; i++) begin
      if (toggle_tick) pci_tick_i = ~pci_tick_i;
      step();
    end
  endtask

  initial begin
    fork
      begin
        strap_pad_i = 5'b10110;
        run(2, 0);
        chk("R2 reset enable low", pad_oe_o, 0);
        chk("R3 reset code zero", freq_code_o, 0);
        chk("R5 reset tick zero", apic_tick_o, 0);
        strap_pad_i = 5'b01101;          // R1: latest level in reset wins
        run(2, 0);
        por_n = 1'b1;
        step();
        chk("R2 enable at first edge", pad_oe_o, 5'h1f);
        chk("R3 strap code", freq_code_o, 5'b01101);
        chk("R4 inverted readback", strap_rb_n_o, 5'b10010);
        strap_pad_i = 5'b11111;          // R1: ignored after release
        run(3, 0);
        chk("R1 pads ignored", freq_code_o, 5'b01101);
        chk("R1 readback held", strap_rb_n_o, 5'b10010);
        pci_tick_i = 1'b1;
        run(10, 1);                      // R5 half rate
        apic_half_i = 1'b0;
        run(6, 1);                       // R5 full rate
        pci_tick_i = 1'b1; step(); step(); // continuous ticks full rate
        apic_half_i = 1'b1;
        step(); step(); step(); step();  // R5 half of continuous ticks
        chk("R5 half alternate", apic_tick_o, 0);
        sw_sel_i = 1'b1; sw_code_i = 5'b10011;
        step();
        chk("R3 software code", freq_code_o, 5'b10011);
        sw_code_i = 5'b00001;
        step(); step();
        chk("R3 software code change", freq_code_o, 5'b00001);
        sw_sel_i = 1'b0;
        step();
        chk("R3 back to straps", freq_code_o, 5'b01101);
        strap_pad_i = 5'b00011;
        por_n = 1'b0;
        run(3, 0);
        por_n = 1'b1;
        step();
        chk("R6 resampled code", freq_code_o, 5'b00011);
        chk("R6 resampled readback", strap_rb_n_o, 5'b11100);
        run(6, 1);
      end
      begin
        while (cycles < 5000) @(negedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected<5000", cycles);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule